// File: doc/BRIEF.md
# Auxiliary-Register Data Address Generator

This block produces the 8-bit data-memory address for each memory-referencing instruction of a small word-oriented signal processor. The address comes from the low byte of the instruction word. Bit 7 of that byte selects one of two modes. In direct mode, a one-bit page value from the status word sits above a 7-bit offset taken from the instruction. In indirect mode, the address is the low byte of whichever auxiliary register the auxiliary pointer selects.

The block also owns the auxiliary registers and the pointer. After an indirect access it can step the selected register up or down and reload the pointer. Both actions are controlled by bits of the same instruction byte. The block also carries three side paths:
- a load-immediate path that writes the instruction's 8-bit constant into a chosen register;
- a store-status form whose direct address is forced onto page 1 and which never changes the pointer;
- a loop-branch request that tests the selected register for a nonzero count and then decrements it.

The address and the branch-taken flag are combinational from the current state and the instruction byte. Register and pointer updates take effect on the clock edge that ends the strobed cycle.

Top module: `aux_addr_gen`

## Requirements
- R1: Instruction bit 7 chooses the mode: 1 means indirect, 0 means direct.
- R2: In direct mode, outside the store-status form, the address is `{page_bit, op_lo[6:0]}`.
- R3: In indirect mode, the address is bits 7:0 of the register selected by the pointer, as it was before any modification in that cycle.
- R4: During an indirect access, bit 5 = 1 with bit 4 = 0 increments the selected register. Bit 4 = 1 with bit 5 = 0 decrements it. Only bits 8:0 change, and they wrap within those 9 bits, so 0x01FF + 1 gives 0x0000 and 0x0000 − 1 gives 0x01FF. Bits 15:9 are kept.
- R5: During an indirect access with both bit 5 and bit 4 set, the selected register is left unchanged.
- R6: After an indirect access outside the store-status form, bit 3 = 0 loads the pointer from instruction bit 0, and bit 3 = 1 keeps it. A direct access never changes the pointer.
- R7: In the store-status form, the direct address is `0x80 | op_lo[6:0]`. An indirect access in this form uses the register address and may still step the register. The pointer is never changed in this form.
- R8: A loop request raises `loop_taken` in the same cycle when bits 8:0 of the selected register are nonzero. Whether or not the branch is taken, those 9 bits are then decremented with 9-bit wrap. Bits 15:9 and the pointer are kept.
- R9: A load-immediate writes the zero-extended `op_lo` into the register numbered by `ldi_sel`. The pointer is not changed.
- R10: Reset (`rst_n` low) clears both registers and the pointer, and holds `loop_taken` low.
- R11: The strobes have a fixed priority: load-immediate first, then loop request, then access. When none is asserted, no register and no pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | Memory-referencing instruction in this cycle |
| op_lo | input | 8 | Low byte of the instruction word |
| page_bit | input | 1 | Data page bit from the status word |
| sst_mode | input | 1 | Current access is the store-status form |
| loop_req | input | 1 | Loop-branch instruction in this cycle |
| ldi_valid | input | 1 | Load-immediate into an auxiliary register |
| ldi_sel | input | 1 | Target register of the load-immediate |
| mem_addr | output | 8 | Data-memory address |
| aux_flat | output | 32 | Auxiliary registers; register 0 in bits 15:0, register 1 in bits 31:16 |
| ptr_q | output | 1 | Auxiliary pointer |
| loop_taken | output | 1 | Loop branch taken |

## Verification
The bench targets the 9-bit wrap in both directions. A design that steps the full 16-bit word would give 0x0200 instead of 0x0000 after an increment, and 0xFFFF instead of 0x01FF after a decrement. It checks that the indirect address uses the value from before the step; a design that used the stepped value would be off by one. It also checks that store-status accesses with bit 3 clear leave the pointer alone, that a cancelling increment/decrement pair holds the register, and that a loop on a zero count is reported not taken yet still wraps to 0x01FF. Overlapping strobes are driven together to show the load-immediate winning and the loop request suppressing the access's pointer reload.

// File: rtl/aux_addr_pkg.sv
package aux_addr_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2,
        STEP_LOAD = 2'd3
    } step_e;

endpackage

// File: rtl/aux_step.sv
module aux_step
    import aux_addr_pkg::*;
#(
    parameter int AR_W  = 16,
    parameter int MOD_W = 9,
    parameter int IMM_W = 8
) (
    input  step_e              step,
    input  logic [AR_W-1:0]    cur,
    input  logic [IMM_W-1:0]   imm,
    output logic [AR_W-1:0]    nxt
);

    logic [MOD_W-1:0] low_cur;
    logic [MOD_W-1:0] low_inc;
    logic [MOD_W-1:0] low_dec;

    always_comb begin
        low_cur = cur[MOD_W-1:0];
        low_inc = low_cur + MOD_W'(1);
        low_dec = low_cur - MOD_W'(1);
        nxt     = cur;
        case (step)
            STEP_INC:  nxt[MOD_W-1:0] = low_inc;
            STEP_DEC:  nxt[MOD_W-1:0] = low_dec;
            STEP_LOAD: nxt = AR_W'(imm);
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/aux_addr_form.sv
module aux_addr_form #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] op_lo,
    input  logic              page_bit,
    input  logic              sst_mode,
    input  logic [ADDR_W-1:0] ind_addr,
    output logic [ADDR_W-1:0] addr,
    output logic              is_ind
);

    localparam int OFS_W = ADDR_W - 1;

    always_comb begin
        is_ind = op_lo[ADDR_W-1];
        if (is_ind)
            addr = ind_addr;
        else if (sst_mode)
            addr = {1'b1, op_lo[OFS_W-1:0]};
        else
            addr = {page_bit, op_lo[OFS_W-1:0]};
    end

endmodule

// File: rtl/aux_addr_gen.sv
module aux_addr_gen
    import aux_addr_pkg::*;
#(
    parameter int AR_W   = 16,
    parameter int MOD_W  = 9,
    parameter int ADDR_W = 8,
    parameter int NUM_AR = 2,
    localparam int PTR_W = (NUM_AR > 1) ? $clog2(NUM_AR) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     acc_valid,
    input  logic [ADDR_W-1:0]        op_lo,
    input  logic                     page_bit,
    input  logic                     sst_mode,
    input  logic                     loop_req,
    input  logic                     ldi_valid,
    input  logic [PTR_W-1:0]         ldi_sel,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [NUM_AR*AR_W-1:0]   aux_flat,
    output logic [PTR_W-1:0]         ptr_q,
    output logic                     loop_taken
);

    localparam int INC_BIT  = 5;
    localparam int DEC_BIT  = 4;
    localparam int KEEP_BIT = 3;

    typedef struct packed {
        logic [NUM_AR-1:0][AR_W-1:0] aux;
        logic [PTR_W-1:0]            ptr;
    } state_t;

    state_t st_q, st_d;

    step_e            step   [NUM_AR];
    logic [AR_W-1:0]  nxt    [NUM_AR];
    logic [AR_W-1:0]  sel_cur;
    step_e            ind_step;
    logic             is_ind;
    logic             do_acc;

    // Register currently addressed by the pointer
    always_comb begin
        sel_cur = '0;
        for (int i = 0; i < NUM_AR; i++)
            if (st_q.ptr == PTR_W'(i)) sel_cur = st_q.aux[i];
    end

    aux_addr_form #(.ADDR_W(ADDR_W)) u_form (
        .op_lo    (op_lo),
        .page_bit (page_bit),
        .sst_mode (sst_mode),
        .ind_addr (sel_cur[ADDR_W-1:0]),
        .addr     (mem_addr),
        .is_ind   (is_ind)
    );

    // Step decode with fixed strobe priority
    always_comb begin
        do_acc = acc_valid && !ldi_valid && !loop_req;
        case ({op_lo[INC_BIT], op_lo[DEC_BIT]})
            2'b10:   ind_step = STEP_INC;
            2'b01:   ind_step = STEP_DEC;
            default: ind_step = STEP_HOLD;
        endcase
        for (int i = 0; i < NUM_AR; i++) begin
            step[i] = STEP_HOLD;
            if (ldi_valid) begin
                if (ldi_sel == PTR_W'(i)) step[i] = STEP_LOAD;
            end else if (loop_req) begin
                if (st_q.ptr == PTR_W'(i)) step[i] = STEP_DEC;
            end else if (acc_valid && is_ind) begin
                if (st_q.ptr == PTR_W'(i)) step[i] = ind_step;
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_AR; g++) begin : g_ar
            aux_step #(.AR_W(AR_W), .MOD_W(MOD_W), .IMM_W(ADDR_W)) u_step (
                .step (step[g]),
                .cur  (st_q.aux[g]),
                .imm  (op_lo),
                .nxt  (nxt[g])
            );
        end
    endgenerate

    // Next-state
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_AR; i++)
            st_d.aux[i] = nxt[i];
        if (do_acc && is_ind && !sst_mode && !op_lo[KEEP_BIT])
            st_d.ptr = op_lo[PTR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < NUM_AR; i++)
            aux_flat[i*AR_W +: AR_W] = st_q.aux[i];
        ptr_q      = st_q.ptr;
        loop_taken = loop_req && !ldi_valid && (sel_cur[MOD_W-1:0] != '0);
    end

    // Assertions
    generate
        for (g = 0; g < NUM_AR; g++) begin : g_chk
            assert_upper_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(ldi_valid) |->
                    (st_q.aux[g][AR_W-1:MOD_W] == $past(st_q.aux[g][AR_W-1:MOD_W])));
        end
    endgenerate

    assert_cancel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_valid && !ldi_valid && !loop_req && op_lo[ADDR_W-1]
              && op_lo[INC_BIT] && op_lo[DEC_BIT]) |-> (st_q.aux == $past(st_q.aux)));

    assert_direct_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_lo[ADDR_W-1] && !sst_mode) |-> (mem_addr[ADDR_W-1] == page_bit));

    assert_sst_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_valid && sst_mode && !ldi_valid && !loop_req) |-> (st_q.ptr == $past(st_q.ptr)));

    assert_loop_dec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(loop_req && !ldi_valid) |->
            (sel_cur[MOD_W-1:0] == MOD_W'($past(sel_cur[MOD_W-1:0]) - MOD_W'(1))));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!acc_valid && !ldi_valid && !loop_req) |-> $stable(st_q));

endmodule

// File: tb/aux_addr_gen_bench.sv
module aux_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [7:0]  op_lo = '0;
    logic        page_bit = 1'b0;
    logic        sst_mode = 1'b0;
    logic        loop_req = 1'b0;
    logic        ldi_valid = 1'b0;
    logic [0:0]  ldi_sel = '0;
    logic [7:0]  mem_addr;
    logic [31:0] aux_flat;
    logic [0:0]  ptr_q;
    logic        loop_taken;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_aux [2];
    logic        m_ptr;

    always #10 clk = ~clk;

    aux_addr_gen u_aux_addr_gen (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .op_lo(op_lo),
        .page_bit(page_bit), .sst_mode(sst_mode), .loop_req(loop_req),
        .ldi_valid(ldi_valid), .ldi_sel(ldi_sel), .mem_addr(mem_addr),
        .aux_flat(aux_flat), .ptr_q(ptr_q), .loop_taken(loop_taken)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk(tag, "aux0", {16'h0, aux_flat[15:0]}, {16'h0, m_aux[0]});
        chk(tag, "aux1", {16'h0, aux_flat[31:16]}, {16'h0, m_aux[1]});
        chk(tag, "ptr", {31'h0, ptr_q}, {31'h0, m_ptr});
    endtask

    // One strobed cycle: drive, check combinational outputs, clock, check state
    task automatic cycle(input logic a, input logic l, input logic ls, input logic lp,
                         input logic [7:0] op, input logic pg, input logic s, input string tag);
        logic [7:0] e_addr;
        logic       e_taken;
        logic [8:0] low;
        @(negedge clk);
        acc_valid = a; ldi_valid = l; ldi_sel = ls; loop_req = lp;
        op_lo = op; page_bit = pg; sst_mode = s;
        if (op[7])      e_addr = m_aux[m_ptr][7:0];
        else if (s)     e_addr = {1'b1, op[6:0]};
        else            e_addr = {pg, op[6:0]};
        e_taken = lp && !l && (m_aux[m_ptr][8:0] != 9'd0);
        #2;
        chk(tag, "mem_addr", {24'h0, mem_addr}, {24'h0, e_addr});
        chk(tag, "loop_taken", {31'h0, loop_taken}, {31'h0, e_taken});
        if (l) begin
            m_aux[ls] = {8'h00, op};
        end else if (lp) begin
            low = m_aux[m_ptr][8:0] - 9'd1;
            m_aux[m_ptr][8:0] = low;
        end else if (a && op[7]) begin
            low = m_aux[m_ptr][8:0];
            if (op[5] && !op[4]) low = low + 9'd1;
            if (op[4] && !op[5]) low = low - 9'd1;
            m_aux[m_ptr][8:0] = low;
            if (!s && !op[3]) m_ptr = op[0];
        end
        @(posedge clk);
        #2;
        chk_state(tag);
        acc_valid = 1'b0; ldi_valid = 1'b0; loop_req = 1'b0; sst_mode = 1'b0;
    endtask

    task automatic t_reset_state;
        chk("R10", "aux_flat", aux_flat, 32'h0);
        chk("R10", "ptr", {31'h0, ptr_q}, 32'h0);
        chk("R10", "loop_taken", {31'h0, loop_taken}, 32'h0);
    endtask

    task automatic t_load_imm;
        cycle(0, 1, 0, 0, 8'h35, 0, 0, "R9");
        cycle(0, 1, 1, 0, 8'hC2, 0, 0, "R9");
    endtask

    task automatic t_direct;
        cycle(1, 0, 0, 0, 8'h12, 0, 0, "R2");
        cycle(1, 0, 0, 0, 8'h7F, 1, 0, "R1");
        cycle(1, 0, 0, 0, 8'h40, 1, 0, "R6");
    endtask

    task automatic t_indirect;
        cycle(1, 0, 0, 0, 8'hA8, 0, 0, "R3");  // inc, keep pointer
        cycle(1, 0, 0, 0, 8'h91, 0, 0, "R4");  // dec, pointer <- 1
        cycle(1, 0, 0, 0, 8'h88, 1, 0, "R1");  // no step
        cycle(1, 0, 0, 0, 8'hB8, 0, 0, "R5");  // both bits cancel
        cycle(1, 0, 0, 0, 8'h80, 0, 0, "R6");  // pointer <- 0
    endtask

    task automatic t_wrap;
        cycle(0, 1, 1, 0, 8'h00, 0, 0, "R9");
        cycle(1, 0, 0, 0, 8'h81, 0, 0, "R6");  // pointer <- 1
        cycle(1, 0, 0, 0, 8'h98, 0, 0, "R4");  // 0 - 1 -> 0x01FF
        cycle(1, 0, 0, 0, 8'hA8, 0, 0, "R4");  // 0x01FF + 1 -> 0
    endtask

    task automatic t_store_status;
        cycle(1, 0, 0, 0, 8'h05, 0, 1, "R7");
        cycle(1, 0, 0, 0, 8'h7E, 1, 1, "R7");
        cycle(1, 0, 0, 0, 8'hA0, 0, 1, "R7");  // bit3 clear, pointer kept
    endtask

    task automatic t_loop;
        cycle(0, 1, 1, 0, 8'h00, 0, 0, "R9");
        cycle(0, 0, 0, 1, 8'h80, 0, 0, "R8");  // zero: not taken, wraps
        cycle(0, 0, 0, 1, 8'h80, 0, 0, "R8");  // taken
        cycle(0, 1, 1, 0, 8'h01, 0, 0, "R9");
        cycle(0, 0, 0, 1, 8'h80, 0, 0, "R8");  // 1: taken, to 0
    endtask

    task automatic t_priority;
        cycle(1, 1, 0, 1, 8'h90, 0, 0, "R11");  // load wins
        cycle(1, 0, 0, 1, 8'h90, 0, 0, "R11");  // loop wins, no pointer reload
        cycle(0, 0, 0, 0, 8'hA0, 1, 0, "R11");  // idle
    endtask

    task automatic t_reset_again;
        cycle(0, 1, 0, 0, 8'h5A, 0, 0, "R9");
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        m_aux[0] = '0; m_aux[1] = '0; m_ptr = 1'b0;
        chk_state("R10");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_aux[0] = '0; m_aux[1] = '0; m_ptr = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        t_reset_state();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_load_imm();
        t_direct();
        t_indirect();
        t_wrap();
        t_store_status();
        t_loop();
        t_priority();
        t_reset_again();
        t_load_imm();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule